// File: doc/BRIEF.md
# Daisy-Chain Monitor Frame Codec

This block turns a write request for a chain of battery-monitor devices into a finished 32-bit frame, and splits a 32-bit frame read back from the chain into its fields. On the way out it packs a 5-bit device address, a 6-bit register address, an 8-bit value and a broadcast flag, appends an 8-bit CRC and a fixed three-bit tail. On the way in it recomputes the CRC over the leading 22 bits and compares it with the byte the frame carries. It also hands out the device, channel, conversion-result, register and register-data fields side by side. Which field set applies depends on the transaction in progress, so the consumer picks the set it needs.

The CRC uses the polynomial x^8+x^5+x^3+x^2+x+1 and starts from zero, taking the leading bits MSB first. Only the leading part of the covered span passes through the shift register. The final byte of the span is XORed onto the register contents without further shifting. A write covers 21 bits and a readback covers 22 bits, so the split point differs by one. The block also drives a constant filler word for cycles in which the host only clocks data back out of the chain. Both directions are combinational and land in a register one clock after their valid strobe.

Top module: `chain_frame_codec`

## Requirements
- R1: A write frame carries the device address in bits [31:27], the register address in [26:21], the data byte in [20:13] and the broadcast flag in bit 12. Bit 11 is 0 and bits [2:0] are 3'b010.
- R2: Write frame bits [10:3] hold the CRC over bits [31:11]. Bits [31:19] are shifted MSB first through an 8-bit register that starts at zero, with polynomial 0x2F. The register contents are then XORed with bits [18:11].
- R3: For a received frame, rx_crc_err_o is 1 exactly when the CRC over bits [31:10] differs from bits [9:2]. Bits [31:18] are shifted and bits [17:10] are XORed in.
- R4: The conversion-result fields are the 4-bit channel address in bits [26:23] and the 12-bit result in bits [22:11].
- R5: The register-readback fields are the 6-bit register address in bits [26:21] and the data byte in bits [20:13].
- R6: rx_dev_o holds received bits [31:27] as they appear. rx_dev_idx_o holds the same five bits in reversed order, so rx_dev_idx_o[4] equals frame bit 27.
- R7: idle_word_o is 32'hF800030A at all times. This is the write frame for device 5'h1F, register 0, data 0, broadcast 0.
- R8: tx_valid_o and rx_valid_o follow their input strobes by one clock. A frame or field output changes only on a clock where its input strobe was 1, and holds otherwise. Reset clears every registered output to 0.
- R9: A write frame shifted right by one bit gives a frame whose bits [31:10] check against bits [9:2]. Fed to the receiver, that shifted frame gives rx_crc_err_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid_i | input | 1 | Write request strobe |
| tx_dev_i | input | 5 | Device address field |
| tx_reg_i | input | 6 | Register address field |
| tx_data_i | input | 8 | Data byte |
| tx_bcast_i | input | 1 | Broadcast-to-all flag |
| tx_valid_o | output | 1 | Write frame valid, one clock after the request |
| tx_frame_o | output | 32 | Finished write frame |
| idle_word_o | output | 32 | Filler word for read-only shifting |
| rx_valid_i | input | 1 | Received frame strobe |
| rx_frame_i | input | 32 | Received frame |
| rx_valid_o | output | 1 | Decoded fields valid, one clock after the strobe |
| rx_dev_o | output | 5 | Device address as on the wire |
| rx_dev_idx_o | output | 5 | Bit-reversed device address |
| rx_chan_o | output | 4 | Conversion channel address |
| rx_result_o | output | 12 | Conversion result |
| rx_reg_o | output | 6 | Readback register address |
| rx_data_o | output | 8 | Readback register data |
| rx_crc_err_o | output | 1 | CRC mismatch flag |

## Verification
The hardest case to reach is an error confined to one half of the CRC span: a single flipped bit among the unshifted tail bits [17:10], compared with one among the shifted head bits. A corrupted frame hides either kind among many valid ones. The bench therefore builds frames with a correct CRC and flips one randomly chosen bit in [31:2], so both kinds, and flips in the CRC byte itself, occur often. It also loops each encoded write frame, shifted by one bit, back into the receiver. The two CRC split points then meet on the same data.

// File: rtl/chain_frame_codec.sv
module chain_frame_codec #(
  parameter logic [7:0] POLY = 8'h2F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_valid_i,
  input  logic [4:0]  tx_dev_i,
  input  logic [5:0]  tx_reg_i,
  input  logic [7:0]  tx_data_i,
  input  logic        tx_bcast_i,
  output logic        tx_valid_o,
  output logic [31:0] tx_frame_o,
  output logic [31:0] idle_word_o,
  input  logic        rx_valid_i,
  input  logic [31:0] rx_frame_i,
  output logic        rx_valid_o,
  output logic [4:0]  rx_dev_o,
  output logic [4:0]  rx_dev_idx_o,
  output logic [3:0]  rx_chan_o,
  output logic [11:0] rx_result_o,
  output logic [5:0]  rx_reg_o,
  output logic [7:0]  rx_data_o,
  output logic        rx_crc_err_o
);

  function automatic logic [7:0] span_crc(input logic [21:0] span);
    logic [7:0] r;
    r = '0;
    for (int i = 21; i >= 8; i--) begin
      if (r[7] ^ span[i]) r = {r[6:0], 1'b0} ^ POLY;
      else                r = {r[6:0], 1'b0};
    end
    return r ^ span[7:0];
  endfunction

  function automatic logic [31:0] pack_write(input logic [4:0] dev, input logic [5:0] rsel,
                                             input logic [7:0] val, input logic bc);
    logic [31:0] f;
    f = {dev, rsel, val, bc, 12'h000};
    f[10:3] = span_crc({1'b0, f[31:11]});
    f[2:0]  = 3'b010;
    return f;
  endfunction

  logic [31:0] tx_next;
  logic        rx_bad;
  logic        unused_tail;

  assign tx_next     = pack_write(tx_dev_i, tx_reg_i, tx_data_i, tx_bcast_i);
  assign idle_word_o = pack_write(5'h1F, 6'h00, 8'h00, 1'b0);
  assign rx_bad      = span_crc(rx_frame_i[31:10]) != rx_frame_i[9:2];
  assign unused_tail = ^rx_frame_i[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid_o <= 1'b0;
      tx_frame_o <= '0;
    end else begin
      tx_valid_o <= tx_valid_i;
      if (tx_valid_i) tx_frame_o <= tx_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid_o   <= 1'b0;
      rx_dev_o     <= '0;
      rx_dev_idx_o <= '0;
      rx_chan_o    <= '0;
      rx_result_o  <= '0;
      rx_reg_o     <= '0;
      rx_data_o    <= '0;
      rx_crc_err_o <= 1'b0;
    end else begin
      rx_valid_o <= rx_valid_i;
      if (rx_valid_i) begin
        rx_dev_o     <= rx_frame_i[31:27];
        rx_dev_idx_o <= {rx_frame_i[27], rx_frame_i[28], rx_frame_i[29],
                         rx_frame_i[30], rx_frame_i[31]};
        rx_chan_o    <= rx_frame_i[26:23];
        rx_result_o  <= rx_frame_i[22:11];
        rx_reg_o     <= rx_frame_i[26:21];
        rx_data_o    <= rx_frame_i[20:13];
        rx_crc_err_o <= rx_bad;
      end
    end
  end

endmodule

// File: rtl/chain_frame_codec_chk.sv
module chain_frame_codec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_valid_i,
  input logic        tx_valid_o,
  input logic [31:0] tx_frame_o,
  input logic        rx_valid_i,
  input logic [31:0] rx_frame_i,
  input logic        rx_valid_o,
  input logic [4:0]  rx_dev_o,
  input logic [4:0]  rx_dev_idx_o,
  input logic        rx_crc_err_o
);

  function automatic logic [7:0] div_crc(input logic [21:0] span);
    logic [21:0] r;
    r = {span[21:8], 8'h00};
    for (int i = 21; i >= 8; i--)
      if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h12F;
    return r[7:0] ^ span[7:0];
  endfunction

  // R8
  tx_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tx_valid_o == $past(tx_valid_i));

  // R8
  rx_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rx_valid_o == $past(rx_valid_i));

  // R1
  tx_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> (tx_frame_o[2:0] == 3'b010 && !tx_frame_o[11]));

  // R9
  tx_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> div_crc({1'b0, tx_frame_o[31:11]}) == tx_frame_o[10:3]);

  // R3
  rx_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_i |=> rx_crc_err_o == (div_crc($past(rx_frame_i[31:10])) != $past(rx_frame_i[9:2])));

  // R6
  rx_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> (rx_dev_idx_o[0] == rx_dev_o[4] && rx_dev_idx_o[1] == rx_dev_o[3] &&
                    rx_dev_idx_o[2] == rx_dev_o[2] && rx_dev_idx_o[3] == rx_dev_o[1] &&
                    rx_dev_idx_o[4] == rx_dev_o[0]));

endmodule

bind chain_frame_codec chain_frame_codec_chk u_chk (.*);

// File: tb/chain_frame_codec_bench.sv
module chain_frame_codec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_valid_i = 1'b0;
  logic [4:0]  tx_dev_i = '0;
  logic [5:0]  tx_reg_i = '0;
  logic [7:0]  tx_data_i = '0;
  logic        tx_bcast_i = 1'b0;
  logic        tx_valid_o;
  logic [31:0] tx_frame_o, idle_word_o;
  logic        rx_valid_i = 1'b0;
  logic [31:0] rx_frame_i = '0;
  logic        rx_valid_o, rx_crc_err_o;
  logic [4:0]  rx_dev_o, rx_dev_idx_o;
  logic [3:0]  rx_chan_o;
  logic [11:0] rx_result_o;
  logic [5:0]  rx_reg_o;
  logic [7:0]  rx_data_o;

  always #2 clk = ~clk;

  chain_frame_codec u_chain_frame_codec (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  int crc_tab [256];

  bit        e_txv, e_rxv, e_err;
  bit [31:0] e_tx, e_rx;
  bit        loop_cycle;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit [7:0] ref_crc(input bit [31:0] v);
    int c;
    c = crc_tab[(v >> 16) & 255];
    c = crc_tab[c ^ ((v >> 8) & 255)];
    return 8'(c ^ (v & 255));
  endfunction

  function automatic bit [31:0] ref_write(input bit [4:0] d, input bit [5:0] r,
                                          input bit [7:0] v, input bit b);
    bit [31:0] f;
    f = (32'(d) << 27) | (32'(r) << 21) | (32'(v) << 13) | (32'(b) << 12);
    f = f | (32'(ref_crc(f >> 11)) << 3) | 32'h2;
    return f;
  endfunction

  function automatic bit [4:0] rev5(input bit [4:0] a);
    bit [4:0] o;
    for (int k = 0; k < 5; k++) o[k] = a[4 - k];
    return o;
  endfunction

  task automatic compare_all();
    chk("R8 tx_valid", 32'(tx_valid_o), 32'(e_txv));
    chk("R8 rx_valid", 32'(rx_valid_o), 32'(e_rxv));
    chk("R1 write fields", 32'(tx_frame_o[31:11]), 32'(e_tx[31:11]));
    chk("R2 write crc", 32'(tx_frame_o[10:3]), 32'(e_tx[10:3]));
    chk("R1 write tail", 32'(tx_frame_o[2:0]), 32'(e_tx[2:0]));
    chk("R3 crc err", 32'(rx_crc_err_o), 32'(e_err));
    chk("R4 chan", 32'(rx_chan_o), 32'(e_rx[26:23]));
    chk("R4 result", 32'(rx_result_o), 32'(e_rx[22:11]));
    chk("R5 reg", 32'(rx_reg_o), 32'(e_rx[26:21]));
    chk("R5 data", 32'(rx_data_o), 32'(e_rx[20:13]));
    chk("R6 dev", 32'(rx_dev_o), 32'(e_rx[31:27]));
    chk("R6 dev idx", 32'(rx_dev_idx_o), 32'(rev5(e_rx[31:27])));
    chk("R7 idle", idle_word_o, 32'hF800030A);
    if (loop_cycle) chk("R9 loopback err", 32'(rx_crc_err_o), 32'h0);
  endtask

  task automatic drive_tx(input bit v, input bit [4:0] d, input bit [5:0] r,
                          input bit [7:0] x, input bit b);
    tx_valid_i = v; tx_dev_i = d; tx_reg_i = r; tx_data_i = x; tx_bcast_i = b;
    e_txv = v;
    if (v) e_tx = ref_write(d, r, x, b);
  endtask

  task automatic drive_rx(input bit v, input bit [31:0] f);
    rx_valid_i = v; rx_frame_i = f;
    e_rxv = v;
    if (v) begin
      e_rx  = f;
      e_err = ref_crc(f >> 10) != f[9:2];
    end
  endtask

  function automatic bit [31:0] good_rx();
    bit [31:0] f;
    f = $urandom;
    f[9:2] = ref_crc(f >> 10);
    return f;
  endfunction

  initial begin
    for (int b = 0; b < 256; b++) begin
      int c;
      c = b;
      for (int k = 0; k < 8; k++)
        c = (c & 8'h80) != 0 ? ((c << 1) ^ 8'h2F) & 8'hFF : (c << 1) & 8'hFF;
      crc_tab[b] = c;
    end
    e_txv = 0; e_rxv = 0; e_err = 0; e_tx = '0; e_rx = '0; loop_cycle = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state, R7 idle constant
    compare_all();
    chk("R8 reset frame", tx_frame_o, 32'h0);

    // R2 boundary: idle encoding and all-zero write
    drive_tx(1, 5'h1F, 6'h00, 8'h00, 0); drive_rx(0, '0);
    @(negedge clk); compare_all();
    chk("R2 idle encode", tx_frame_o, 32'hF800030A);
    drive_tx(1, 5'h00, 6'h00, 8'h00, 0);
    @(negedge clk); compare_all();
    chk("R1 zero write", tx_frame_o, 32'h00000002);
    drive_tx(1, 5'h1F, 6'h3F, 8'hFF, 1);
    drive_rx(1, 32'hFFFFFFFF);
    @(negedge clk); compare_all();

    for (int n = 0; n < 3000; n++) begin
      bit [31:0] f;
      loop_cycle = 0;
      case (n % 4)
        0: begin
          drive_tx(1, 5'($urandom), 6'($urandom), 8'($urandom), 1'($urandom));
          drive_rx(1, good_rx());
        end
        1: begin
          drive_tx(0, 5'($urandom), 6'($urandom), 8'($urandom), 1'($urandom));
          drive_rx(0, $urandom);
        end
        2: begin
          drive_rx(1, {1'b0, e_tx[31:1]});
          loop_cycle = 1;
          drive_tx(1, 5'($urandom), 6'($urandom), 8'($urandom), 1'($urandom));
        end
        default: begin
          f = good_rx();
          f[2 + ($urandom % 30)] ^= 1'b1;
          drive_rx(1, f);
          drive_tx($urandom % 2 == 0, 5'($urandom), 6'($urandom), 8'($urandom), 1'($urandom));
        end
      endcase
      @(negedge clk);
      compare_all();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule